// File: doc/BRIEF.md
# FSK Manchester Tag Demodulator

This block takes a stream of 8-bit envelope samples from a low-frequency reader, one sample for each carrier cycle, and recovers the 44-bit identifier that a frequency-shift-keyed tag sends. Each sample is sliced to a single bit. The spacing between rising edges of the sliced signal marks every subcarrier cycle as short (divide-by-8) or long (divide-by-10). Runs of cycles in the same class are then rounded to a count of half-bit symbols.

A framer scans the half-bit stream for the illegal six-symbol start pattern. After that pattern it decodes Manchester pairs into a shift register. When the next start pattern arrives and the register holds a nonzero value, the block reports that value with a one-cycle valid pulse.

The sample source drives `smp_valid` high for every sample it delivers. The consumer reads `id` when `id_valid` is high, or at any later time, because `id` keeps the last value reported.

Top module: `fsk_tag_demod`

## Requirements
- R1: A sample below the slice level (default 127) slices to 0. A sample at or above that level slices to 1, so 127 slices to 1 and 126 slices to 0.
- R2: A cycle with `smp_valid` low has no effect on slicing, edge timing or decoding, whatever `smp_data` holds.
- R3: The first 0-to-1 transition of the sliced signal only arms the measurement. Each later rising edge classifies the interval since the previous rising edge: fewer than 9 samples is short, 9 or more is long. Intervals of 7 and 8 therefore count as short, and 9 and 11 count as long.
- R4: When the cycle class changes, the run that just ended becomes (n+1)/6 half-bits if it was short and (n+1)/5 half-bits if it was long, using integer division. A count of 1 to 4 emits that many half-bits, at level 1 for a short run and level 0 for a long run. Any other count emits nothing, so a single stray short cycle adds no half-bit.
- R5: The run-length counter saturates at its maximum value (255 by default) instead of wrapping.
- R6: The half-bit sequence 1,1,1,0,0,0 (oldest first) is a start marker. The framer finds it at any position while searching, and at pair boundaries while inside a frame.
- R7: Inside a frame, the pair 1,0 decodes to bit 0 and the pair 0,1 decodes to bit 1. Each bit shifts in at the LSB, so the first bit after the marker ends up as the MSB of a full 44-bit identifier.
- R8: Inside a frame, a pair 0,0 or 1,1 sends the framer back to searching. The next marker then produces no report.
- R9: A marker seen inside a frame with a nonzero register raises `id_valid` for one cycle with `id` equal to the register. Every marker clears the register. A zero register produces no report.
- R10: While reset is held and after it is released, `id_valid` is 0 and `id` is 0.
- R11: `id` changes only in a cycle where `id_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Qualifies `smp_data` for this cycle |
| smp_data | input | 8 | Envelope sample (SAMPLE_W) |
| id_valid | output | 1 | One-cycle pulse when an identifier is reported |
| id | output | 44 | Last identifier reported (ID_W) |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a slice level of 127, a short-cycle limit of 9, divisors 6 and 5, a 44-bit identifier and an 8-bit run counter. With an 8-bit run counter the bench can reach saturation using a long run of 271 cycles, and a counter that wrapped instead would turn that run into a false start marker. Waveforms are built from tag-like half-bits under several conditions: sample gaps filled with misleading data, interval jitter at the class boundaries, samples exactly at the slice level, and stray single short cycles before every fourth bit. The framing corners covered are all-zero frames, short frames that show the register clears, and illegal pairs.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

    // one classified subcarrier cycle
    typedef struct packed {
        logic valid;
        logic is_short;
    } cyc_evt_t;

    // a group of identical half-bit symbols released by a finished run
    typedef struct packed {
        logic       valid;
        logic [2:0] count;
        logic       level;
    } hb_grp_t;

    typedef enum logic {
        FS_SEARCH = 1'b0,
        FS_FRAME  = 1'b1
    } frame_state_t;

    localparam logic [5:0] MARKER_PAT = 6'b111000;
    localparam int         MAX_GROUP  = 4;
    localparam logic [2:0] WIN_FULL   = 3'd6;

    // half-bits represented by a run; zero when outside 1..MAX_GROUP
    function automatic logic [2:0] group_size(input int run, input int divisor);
        int q;
        q = (run + 1) / divisor;
        if (q >= 1 && q <= MAX_GROUP) return q[2:0];
        return 3'd0;
    endfunction

endpackage

// File: rtl/fsk_edge_meter.sv
module fsk_edge_meter
    import fsk_demod_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SLICE_LEVEL = 127,
    parameter int SHORT_LIMIT = 9,
    parameter int PER_W       = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output cyc_evt_t            evt
);
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    logic             prev_bit;
    logic             armed;
    logic [PER_W-1:0] per_cnt;
    logic             cur_bit;
    logic             rise;

    always_comb begin
        cur_bit = (smp_data >= SAMPLE_W'(SLICE_LEVEL));
        rise    = !prev_bit && cur_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bit <= 1'b1;
            armed    <= 1'b0;
            per_cnt  <= '0;
            evt      <= '0;
        end else begin
            evt.valid <= 1'b0;
            if (smp_valid) begin
                prev_bit <= cur_bit;
                if (rise) begin
                    if (armed) begin
                        evt.valid    <= 1'b1;
                        evt.is_short <= (per_cnt < PER_W'(SHORT_LIMIT));
                    end
                    armed   <= 1'b1;
                    per_cnt <= PER_W'(1);
                end else if (per_cnt != PER_MAX) begin
                    per_cnt <= per_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fsk_run_grouper.sv
module fsk_run_grouper
    import fsk_demod_pkg::*;
#(
    parameter int RUN_W     = 8,
    parameter int DIV_SHORT = 6,
    parameter int DIV_LONG  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_evt_t         evt,
    output hb_grp_t          grp,
    output logic [RUN_W-1:0] run_len
);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic             have_cls;
    logic             last_short;
    logic [RUN_W-1:0] run_q;
    logic [2:0]       emit_cnt;

    always_comb begin
        emit_cnt = group_size(int'(32'(run_q)), last_short ? DIV_SHORT : DIV_LONG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_cls   <= 1'b0;
            last_short <= 1'b0;
            run_q      <= '0;
            grp        <= '0;
        end else begin
            grp.valid <= 1'b0;
            if (evt.valid) begin
                if (!have_cls) begin
                    have_cls   <= 1'b1;
                    last_short <= evt.is_short;
                    run_q      <= RUN_W'(1);
                end else if (evt.is_short == last_short) begin
                    if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
                end else begin
                    if (emit_cnt != 3'd0) begin
                        grp.valid <= 1'b1;
                        grp.count <= emit_cnt;
                        grp.level <= last_short;
                    end
                    last_short <= evt.is_short;
                    run_q      <= RUN_W'(1);
                end
            end
        end
    end

    assign run_len = run_q;
endmodule

// File: rtl/fsk_frame_decoder.sv
module fsk_frame_decoder
    import fsk_demod_pkg::*;
#(
    parameter int ID_W = 44
) (
    input  logic            clk,
    input  logic            rst,
    input  hb_grp_t         grp,
    output logic            id_valid,
    output logic [ID_W-1:0] id
);
    // six-symbol look-ahead window; newest symbol in bit 0
    logic [5:0]      win_q,  n_win;
    logic [2:0]      pend_q, n_pend;
    frame_state_t    st_q,   n_st;
    logic [ID_W-1:0] acc_q,  n_acc;
    logic            rep;
    logic [ID_W-1:0] rep_val;

    always_comb begin
        n_win   = win_q;
        n_pend  = pend_q;
        n_st    = st_q;
        n_acc   = acc_q;
        rep     = 1'b0;
        rep_val = '0;
        if (grp.valid) begin
            for (int k = 0; k < MAX_GROUP; k++) begin
                if (k < int'(32'(grp.count))) begin
                    n_win  = {n_win[4:0], grp.level};
                    n_pend = n_pend + 3'd1;
                    if (n_pend == WIN_FULL) begin
                        if (n_win == MARKER_PAT) begin
                            if (n_st == FS_FRAME && n_acc != '0) begin
                                rep     = 1'b1;
                                rep_val = n_acc;
                            end
                            n_acc  = '0;
                            n_st   = FS_FRAME;
                            n_pend = 3'd0;
                        end else if (n_st == FS_FRAME) begin
                            if (n_win[5] != n_win[4]) begin
                                n_acc = {n_acc[ID_W-2:0], n_win[4]};
                            end else begin
                                n_st = FS_SEARCH;
                            end
                            n_pend = 3'd4;
                        end else begin
                            n_pend = 3'd5;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            pend_q   <= '0;
            st_q     <= FS_SEARCH;
            acc_q    <= '0;
            id_valid <= 1'b0;
            id       <= '0;
        end else begin
            win_q    <= n_win;
            pend_q   <= n_pend;
            st_q     <= n_st;
            acc_q    <= n_acc;
            id_valid <= rep;
            if (rep) id <= rep_val;
        end
    end
endmodule

// File: rtl/fsk_tag_demod.sv
module fsk_tag_demod
    import fsk_demod_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SLICE_LEVEL = 127,
    parameter int SHORT_LIMIT = 9,
    parameter int PER_W       = 6,
    parameter int RUN_W       = 8,
    parameter int DIV_SHORT   = 6,
    parameter int DIV_LONG    = 5,
    parameter int ID_W        = 44
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                id_valid,
    output logic [ID_W-1:0]     id
);
    cyc_evt_t         cyc_evt;
    hb_grp_t          hb_grp;
    logic [RUN_W-1:0] run_len;

    fsk_edge_meter #(
        .SAMPLE_W(SAMPLE_W), .SLICE_LEVEL(SLICE_LEVEL),
        .SHORT_LIMIT(SHORT_LIMIT), .PER_W(PER_W)
    ) u_edge (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .evt(cyc_evt)
    );

    fsk_run_grouper #(
        .RUN_W(RUN_W), .DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG)
    ) u_runs (
        .clk(clk), .rst(rst), .evt(cyc_evt), .grp(hb_grp), .run_len(run_len)
    );

    fsk_frame_decoder #(
        .ID_W(ID_W)
    ) u_frame (
        .clk(clk), .rst(rst), .grp(hb_grp), .id_valid(id_valid), .id(id)
    );
endmodule

// File: rtl/fsk_tag_demod_chk.sv
module fsk_tag_demod_chk #(
    parameter int ID_W  = 44,
    parameter int RUN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             cyc_valid,
    input logic             hb_valid,
    input logic [2:0]       hb_cnt,
    input logic [RUN_W-1:0] run_len,
    input logic             id_valid,
    input logic [ID_W-1:0]  id
);
    // R2: an invalid sample never produces a cycle event
    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !cyc_valid);

    // R4: released groups always hold 1 to 4 half-bits
    assert_grp_range_R4: assert property (@(posedge clk) disable iff (rst)
        hb_valid |-> (hb_cnt >= 3'd1 && hb_cnt <= 3'd4));

    // R5: the run length only falls when a new run restarts at one
    assert_run_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (run_len < $past(run_len)) |-> (run_len == RUN_W'(1)));

    // R9: a report is a single-cycle pulse
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> !id_valid);

    // R9: a reported identifier is never zero
    assert_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> (id != '0));

    // R10: outputs are clear right after reset
    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!id_valid && id == '0));

    // R11: the identifier holds between reports
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> $stable(id));
endmodule

bind fsk_tag_demod fsk_tag_demod_chk #(.ID_W(ID_W), .RUN_W(RUN_W)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .cyc_valid(cyc_evt.valid), .hb_valid(hb_grp.valid), .hb_cnt(hb_grp.count),
    .run_len(run_len), .id_valid(id_valid), .id(id)
);

// File: tb/fsk_tag_demod_test.sv
module fsk_tag_demod_test;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W       = 44;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            smp_valid = 1'b0;
    logic [7:0]      smp_data = 8'h00;
    logic            id_valid;
    logic [ID_W-1:0] id;

    int checks = 0;
    int fails  = 0;
    int rep_cnt = 0;
    logic [ID_W-1:0] rep_id = '0;
    bit gap_mode = 1'b0;
    bit jitter_mode = 1'b0;
    int gap_ctr = 0;
    bit tog_s = 1'b0;
    bit tog_l = 1'b0;

    fsk_tag_demod uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .id_valid(id_valid), .id(id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && id_valid) begin
            rep_cnt = rep_cnt + 1;
            rep_id  = id;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_sample(input logic [7:0] v);
        if (gap_mode) begin
            gap_ctr++;
            if (gap_ctr % 3 == 0) begin
                @(negedge clk); smp_valid = 1'b0; smp_data = 8'hF0;
                @(negedge clk); smp_valid = 1'b0; smp_data = 8'h00;
            end
        end
        @(negedge clk); smp_valid = 1'b1; smp_data = v;
    endtask

    task automatic send_cycle(input bit is_short);
        int len;
        int hi_n;
        logic [7:0] hv;
        logic [7:0] lv;
        hv = jitter_mode ? 8'd127 : 8'd200;
        lv = jitter_mode ? 8'd126 : 8'd30;
        if (is_short) begin
            len = (jitter_mode && tog_s) ? 7 : 8;
            tog_s = !tog_s;
            hi_n = 2;
        end else begin
            len = jitter_mode ? (tog_l ? 9 : 11) : 10;
            tog_l = !tog_l;
            hi_n = 3;
        end
        for (int i = 0; i < len; i++) drive_sample(i < hi_n ? hv : lv);
    endtask

    task automatic send_half(input bit lvl);
        repeat (lvl ? 6 : 5) send_cycle(lvl);
    endtask

    task automatic send_bit(input bit b);
        if (b) begin send_half(1'b0); send_half(1'b1); end
        else   begin send_half(1'b1); send_half(1'b0); end
    endtask

    task automatic send_marker();
        send_half(1'b1); send_half(1'b1); send_half(1'b1);
        send_half(1'b0); send_half(1'b0); send_half(1'b0);
    endtask

    task automatic send_id(input logic [ID_W-1:0] v, input int nbits, input bit stray);
        for (int i = nbits - 1; i >= 0; i--) begin
            if (stray && (i % 4) == 3) send_cycle(1'b1);
            send_bit(v[i]);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); smp_valid = 1'b0; smp_data = 8'h00;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_clean();
        @(negedge clk); rst = 1'b1; smp_valid = 1'b0;
        gap_mode = 1'b0; jitter_mode = 1'b0; tog_s = 1'b0; tog_l = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rep_cnt = 0; rep_id = '0;
        send_half(1'b0); send_half(1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "id_valid in reset", 64'(id_valid), 64'd0);
        check("R10", "id in reset", 64'(id), 64'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R10", "id_valid after reset", 64'(id_valid), 64'd0);
        check("R10", "id after reset", 64'(id), 64'd0);
    endtask

    task automatic t_basic();
        logic [ID_W-1:0] v = 44'hA5C396E17B4;
        start_clean();
        send_marker(); send_id(v, ID_W, 1'b0); send_marker(); send_half(1'b1);
        idle(20);
        check("R6", "report count", 64'(rep_cnt), 64'd1);
        check("R7", "identifier MSB first", 64'(rep_id), 64'(v));
        idle(30);
        check("R11", "id holds after report", 64'(id), 64'(v));
        check("R9", "pulse ended", 64'(id_valid), 64'd0);
    endtask

    task automatic t_gaps();
        logic [ID_W-1:0] v = 44'h0123456789A;
        start_clean();
        gap_mode = 1'b1;
        send_marker(); send_id(v, ID_W, 1'b0); send_marker(); send_half(1'b1);
        idle(20);
        check("R2", "report count with gaps", 64'(rep_cnt), 64'd1);
        check("R2", "identifier with gaps", 64'(rep_id), 64'(v));
    endtask

    task automatic t_jitter();
        logic [ID_W-1:0] v = 44'hFEDCBA98765;
        start_clean();
        jitter_mode = 1'b1;
        send_marker(); send_id(v, ID_W, 1'b1); send_marker(); send_half(1'b1);
        idle(20);
        check("R3", "report count with jitter", 64'(rep_cnt), 64'd1);
        check("R1", "identifier at slice level", 64'(rep_id), 64'(v));
        check("R4", "stray cycles add nothing", 64'(rep_id), 64'(v));
    endtask

    task automatic t_zero_clear();
        start_clean();
        send_marker(); send_id('0, ID_W, 1'b0);
        send_marker(); send_id(44'hFF, 8, 1'b0);
        send_marker(); send_id(44'hB, 4, 1'b0);
        send_marker(); send_half(1'b1);
        idle(20);
        check("R9", "zero frame not reported", 64'(rep_cnt), 64'd2);
        check("R9", "register cleared at marker", 64'(rep_id), 64'hB);
    endtask

    task automatic t_bad_pair();
        start_clean();
        send_marker(); send_bit(1'b1);
        send_half(1'b1); send_half(1'b1);
        send_bit(1'b0); send_bit(1'b0);
        send_marker(); send_bit(1'b1);
        send_marker(); send_half(1'b1);
        idle(20);
        check("R8", "report count after bad pair", 64'(rep_cnt), 64'd1);
        check("R8", "identifier after resync", 64'(rep_id), 64'd1);
    endtask

    task automatic t_saturate();
        start_clean();
        send_half(1'b1); send_half(1'b1); send_half(1'b1);
        repeat (271) send_cycle(1'b0);
        send_half(1'b1); send_half(1'b0); send_half(1'b0); send_half(1'b1);
        send_marker(); send_half(1'b1);
        idle(20);
        check("R5", "long run yields no marker", 64'(rep_cnt), 64'd0);
        check("R5", "id untouched", 64'(id), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_gaps();
        t_jitter();
        t_zero_clear();
        t_bad_pair();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule